// File: doc/BRIEF.md
# Partition Power Gate Controller

This block sits on a simple 32-bit register bus and switches power partitions on or off one at a time. For each partition it drives a power-switch request and an isolation clamp, and it watches an acknowledge that comes back from the analog switch. Software issues a toggle command with a partition index. The block flips that partition's power state, handles the request/acknowledge exchange, and keeps a busy flag set until the exchange is done.

Releasing a clamp is a separate command. Software writes a one-hot word to the clamp command register. The bit stays set for a fixed number of cycles, then clears itself, and the partition's clamp drops. The block accepts this command only for a partition that is already powered. When a partition powers down, its clamp is raised before its switch request is withdrawn.

Top module: `pgate_ctrl`

Register words (busAddr): 0 = toggle, 1 = power status, 2 = clamp command, 3 = clamp status.

## Requirements
- R1: After reset, every partition not in ALWAYS_ON reads 0 in power status (word 1), reads 1 in clamp status (word 3) and has swReq low and clampEn high. Word 0 and word 2 read 0.
- R2: After reset, every partition in ALWAYS_ON reads powered, reads unclamped and has swReq high.
- R3: When the block is idle, a write to word 0 with bit 8 set and an index below NUM_PART in bits 4:0 starts a toggle. For an unpowered partition, swReq rises at that edge and word 0 reads the index with bit 8 set. When swAck is seen high, the power status bit is set and bit 8 clears.
- R4: A toggle of a powered partition raises its clampEn at the accepting edge and lowers its swReq one cycle later. The power status bit clears once swAck is seen low.
- R5: A toggle write with bit 8 set that arrives while bit 8 reads 1 is dropped and sets a sticky error flag at word 0 bit 16.
- R6: A write to word 0 without bit 8, or with an index of NUM_PART or more, starts nothing and leaves word 0 unchanged.
- R7: A clamp command write with exactly one bit set, for a powered and idle partition, makes that bit read 1 for REL_CYCLES cycles. The bit then clears, and the partition's clamp status bit and clampEn go to 0.
- R8: A clamp command for an unpowered partition, or for a partition whose toggle is in flight, is ignored. Word 2 reads 0 and the clamp stays asserted.
- R9: A clamp command word without exactly one bit set, or any clamp command written while a removal is pending, is ignored.
- R10: Power status bits change only at the end of a toggle. While the block is idle, swReq equals the power status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrite | input | 1 | Write strobe for one cycle |
| busAddr | input | 2 | Register word select |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| swAck | input | NUM_PART | Power-switch acknowledge per partition |
| swReq | output | NUM_PART | Power-switch request per partition |
| clampEn | output | NUM_PART | Isolation clamp enable per partition |

## Verification
The bench tests the order of events at power-down. If the clamp and the request changed on the same edge, outputs would go unisolated while the rail collapses. It writes a second toggle straight after the first, so a design that re-armed would corrupt an unrelated partition and leave the error flag clear. It sends clamp commands to an unpowered partition, to a partition in mid-toggle, as a two-hot word, and during a pending removal. A design that ignored any of these rules would unclamp a dead partition or release two clamps at once. It also counts the exact cycles the command bit stays set, so an off-by-one in the release timer shows up.

// File: rtl/pgate_pkg.sv
package pgate_pkg;
  localparam int IDX_W = 5;
  localparam int START_BIT = 8;
  localparam int ERR_BIT = 16;

  typedef enum logic [1:0] {
    A_TOGGLE    = 2'd0,
    A_POWER     = 2'd1,
    A_CLAMPCMD  = 2'd2,
    A_CLAMPSTAT = 2'd3
  } pgAddr_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic             reqSet;
    logic             reqClr;
    logic             clampSet;
    logic             pwrSet;
    logic             pwrClr;
    logic [IDX_W-1:0] tIdx;
    logic             cmdSet;
    logic             cmdClr;
    logic             clampClr;
    logic [IDX_W-1:0] cIdx;
    logic             errSet;
  } pgStrobe_t;
endpackage

// File: rtl/pgate_ctl.sv
module pgate_ctl
  import pgate_pkg::*;
#(
  parameter int NUM_PART   = 8,
  parameter int REL_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrite,
  input  logic [1:0]          busAddr,
  input  logic [31:0]         busWdata,
  input  logic [NUM_PART-1:0] powered,
  input  logic [NUM_PART-1:0] swAck,
  output pgStrobe_t           stb,
  output logic                busy,
  output logic [IDX_W-1:0]    tglIdx
);
  localparam int CNT_W = (REL_CYCLES > 1) ? $clog2(REL_CYCLES) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ON_WAIT, S_OFF_CLAMP, S_OFF_WAIT} tglState_t;

  tglState_t        state, nxtState;
  logic [31:0]      powW, ackW;
  logic             wrTgl, wrCmd, idxOk, oneHot, cmdOk;
  logic [IDX_W-1:0] reqIdx, cmdIdx, relIdx;
  logic             relBusy;
  logic [CNT_W-1:0] relCnt;

  assign powW   = 32'(powered);
  assign ackW   = 32'(swAck);
  assign reqIdx = busWdata[IDX_W-1:0];
  assign wrTgl  = busWrite && (busAddr == A_TOGGLE) && busWdata[START_BIT];
  assign wrCmd  = busWrite && (busAddr == A_CLAMPCMD);
  assign idxOk  = ({1'b0, reqIdx} < 6'(NUM_PART));
  assign oneHot = ($countones(busWdata) == 1);
  assign busy   = (state != S_IDLE);

  always_comb begin
    cmdIdx = '0;
    for (int i = 0; i < 32; i++)
      if (busWdata[i]) cmdIdx = IDX_W'(i);
  end

  assign cmdOk = powW[cmdIdx] && !(busy && (tglIdx == cmdIdx));

  always_comb begin
    stb      = '0;
    nxtState = state;
    case (state)
      S_IDLE: if (wrTgl && idxOk) begin
        stb.tIdx = reqIdx;
        if (powW[reqIdx]) begin
          stb.clampSet = 1'b1;
          nxtState     = S_OFF_CLAMP;
        end else begin
          stb.reqSet = 1'b1;
          nxtState   = S_ON_WAIT;
        end
      end
      S_ON_WAIT: begin
        stb.tIdx = tglIdx;
        if (ackW[tglIdx]) begin
          stb.pwrSet = 1'b1;
          nxtState   = S_IDLE;
        end
      end
      S_OFF_CLAMP: begin
        stb.tIdx   = tglIdx;
        stb.reqClr = 1'b1;
        nxtState   = S_OFF_WAIT;
      end
      default: begin
        stb.tIdx = tglIdx;
        if (!ackW[tglIdx]) begin
          stb.pwrClr = 1'b1;
          nxtState   = S_IDLE;
        end
      end
    endcase
    stb.errSet = busy && wrTgl;
    // clamp release engine
    if (relBusy) begin
      stb.cIdx = relIdx;
      if (stb.clampSet && (stb.tIdx == relIdx)) begin
        stb.cmdClr = 1'b1;                 // power-off cancels pending removal
      end else if (relCnt == '0) begin
        stb.cmdClr   = 1'b1;
        stb.clampClr = 1'b1;
      end
    end else if (wrCmd && oneHot && cmdOk) begin
      stb.cIdx   = cmdIdx;
      stb.cmdSet = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tglIdx  <= '0;
      relBusy <= 1'b0;
      relIdx  <= '0;
      relCnt  <= '0;
    end else begin
      state <= nxtState;
      if (state == S_IDLE && nxtState != S_IDLE) tglIdx <= reqIdx;
      if (stb.cmdSet) begin
        relBusy <= 1'b1;
        relIdx  <= stb.cIdx;
        relCnt  <= CNT_W'(REL_CYCLES - 1);
      end else if (stb.cmdClr) begin
        relBusy <= 1'b0;
      end else if (relBusy) begin
        relCnt <= relCnt - CNT_W'(1);
      end
    end
  end

  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(tglIdx));
  // R9
  rel_no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (relBusy && !stb.cmdClr) |=> (relBusy && $stable(relIdx)));
endmodule

// File: rtl/pgate_dp.sv
module pgate_dp
  import pgate_pkg::*;
#(
  parameter int          NUM_PART  = 8,
  parameter logic [31:0] ALWAYS_ON = 32'h1
) (
  input  logic                clk,
  input  logic                rstN,
  input  pgStrobe_t           stb,
  input  logic [1:0]          busAddr,
  input  logic                busy,
  input  logic [IDX_W-1:0]    tglIdx,
  output logic [NUM_PART-1:0] powered,
  output logic [NUM_PART-1:0] swReq,
  output logic [NUM_PART-1:0] clampEn,
  output logic [31:0]         busRdata
);
  localparam logic [NUM_PART-1:0] AON = ALWAYS_ON[NUM_PART-1:0];

  logic [NUM_PART-1:0] powReg, reqReg, clampReg, cmdReg, tM, cM;
  logic                errReg;

  always_comb begin
    for (int i = 0; i < NUM_PART; i++) begin
      tM[i] = (stb.tIdx == IDX_W'(i));
      cM[i] = (stb.cIdx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powReg   <= AON;
      reqReg   <= AON;
      clampReg <= ~AON;
      cmdReg   <= '0;
      errReg   <= 1'b0;
    end else begin
      if (stb.pwrSet)      powReg <= powReg | tM;
      else if (stb.pwrClr) powReg <= powReg & ~tM;
      if (stb.reqSet)      reqReg <= reqReg | tM;
      else if (stb.reqClr) reqReg <= reqReg & ~tM;
      clampReg <= (clampReg & ~(stb.clampClr ? cM : '0)) | (stb.clampSet ? tM : '0);
      if (stb.cmdSet)      cmdReg <= cmdReg | cM;
      else if (stb.cmdClr) cmdReg <= cmdReg & ~cM;
      if (stb.errSet)      errReg <= 1'b1;
    end
  end

  assign powered = powReg;
  assign swReq   = reqReg;
  assign clampEn = clampReg;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_TOGGLE: begin
        busRdata[IDX_W-1:0] = tglIdx;
        busRdata[START_BIT] = busy;
        busRdata[ERR_BIT]   = errReg;
      end
      A_POWER:    busRdata = 32'(powReg);
      A_CLAMPCMD: busRdata = 32'(cmdReg);
      default:    busRdata = 32'(clampReg);
    endcase
  end

  // R4
  clamp_before_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(reqReg) & ~reqReg & ~$past(clampReg)) == '0));
  // R7
  release_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(clampReg) & ~clampReg & ~powReg) == '0));
  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errReg |=> errReg);
  // R10
  power_only_in_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (powReg != $past(powReg)) |-> $past(busy));
  // R10
  idle_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (reqReg == powReg));
  // R9
  cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(cmdReg));
endmodule

// File: rtl/pgate_ctrl.sv
module pgate_ctrl
  import pgate_pkg::*;
#(
  parameter int          NUM_PART   = 8,
  parameter logic [31:0] ALWAYS_ON  = 32'h1,
  parameter int          REL_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWrite,
  input  logic [1:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [NUM_PART-1:0] swAck,
  output logic [NUM_PART-1:0] swReq,
  output logic [NUM_PART-1:0] clampEn
);
  pgStrobe_t           stb;
  logic                busy;
  logic [IDX_W-1:0]    tglIdx;
  logic [NUM_PART-1:0] powered;

  pgate_ctl #(.NUM_PART(NUM_PART), .REL_CYCLES(REL_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .powered(powered), .swAck(swAck),
    .stb(stb), .busy(busy), .tglIdx(tglIdx)
  );

  pgate_dp #(.NUM_PART(NUM_PART), .ALWAYS_ON(ALWAYS_ON)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busy(busy),
    .tglIdx(tglIdx), .powered(powered), .swReq(swReq), .clampEn(clampEn),
    .busRdata(busRdata)
  );
endmodule

// File: tb/sim_pgate_ctrl.sv
`timescale 1ns/1ps
module sim_pgate_ctrl;
  localparam int          N   = 8;
  localparam logic [31:0] AON = 32'h1;
  localparam int          REL = 4;
  localparam int          ACK_DLY = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busWrite = 1'b0;
  logic [1:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [N-1:0]  swAck = AON[N-1:0];
  logic [N-1:0]  swReq, clampEn;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pgate_ctrl #(.NUM_PART(N), .ALWAYS_ON(AON), .REL_CYCLES(REL)) u0 (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .swAck(swAck),
    .swReq(swReq), .clampEn(clampEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // analog switch responder
  int ackCnt [N];
  always @(posedge clk) begin
    if (!rstN) begin
      swAck <= AON[N-1:0];
      for (int i = 0; i < N; i++) ackCnt[i] = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (swAck[i] != swReq[i]) begin
          if (ackCnt[i] >= ACK_DLY - 1) begin
            swAck[i] <= swReq[i];
            ackCnt[i] = 0;
          end else ackCnt[i]++;
        end else ackCnt[i] = 0;
      end
    end
  end

  // behavioural reference model
  bit [N-1:0] mPow = AON[N-1:0], mReq = AON[N-1:0], mClamp = ~AON[N-1:0], mCmd = '0;
  bit mErr = 0, relBusy = 0;
  int phase = 0, tIdx = 0, relIdx = 0, relLeft = 0;

  always @(posedge clk) begin : model
    bit tw, cw, accOff, wasBusy;
    int wi, ci;
    if (!rstN) begin
      mPow = AON[N-1:0]; mReq = AON[N-1:0]; mClamp = ~AON[N-1:0]; mCmd = '0;
      mErr = 0; relBusy = 0; phase = 0; tIdx = 0;
    end else begin
      tw = busWrite && busAddr == 2'd0 && busWdata[8];
      wi = int'(busWdata[4:0]);
      cw = busWrite && busAddr == 2'd2;
      wasBusy = (phase != 0);
      accOff = !wasBusy && tw && wi < N && mPow[wi];
      if (relBusy) begin
        if (accOff && wi == relIdx) begin mCmd[relIdx] = 0; relBusy = 0; end
        else if (relLeft == 0) begin mCmd[relIdx] = 0; mClamp[relIdx] = 0; relBusy = 0; end
        else relLeft--;
      end else if (cw && $countones(busWdata) == 1) begin
        ci = 0;
        for (int k = 0; k < 32; k++) if (busWdata[k]) ci = k;
        if (ci < N && mPow[ci] && !(wasBusy && tIdx == ci)) begin
          relBusy = 1; relIdx = ci; relLeft = REL - 1; mCmd[ci] = 1;
        end
      end
      case (phase)
        0: if (tw && wi < N) begin
             tIdx = wi;
             if (mPow[wi]) begin mClamp[wi] = 1; phase = 2; end
             else begin mReq[wi] = 1; phase = 1; end
           end
        1: if (swAck[tIdx]) begin mPow[tIdx] = 1; phase = 0; end
        2: begin mReq[tIdx] = 0; phase = 3; end
        default: if (!swAck[tIdx]) begin mPow[tIdx] = 0; phase = 0; end
      endcase
      if (wasBusy && tw) mErr = 1;
    end
  end

  // compare ports with the model on every clock
  always @(negedge clk) begin
    if (rstN) begin
      chk("R3 swReq vs model", 32'(swReq), 32'(mReq));
      chk("R4 clampEn vs model", 32'(clampEn), 32'(mClamp));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrite = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int k = 0; k < 60; k++) begin
      rd(2'd0, v);
      if (!v[8]) break;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 / R2 reset state
    rd(2'd1, v); chk("R1 power status", v, 32'h01);
    rd(2'd3, v); chk("R1 clamp status", v, 32'hFE);
    rd(2'd0, v); chk("R1 toggle word", v, 32'h0);
    rd(2'd2, v); chk("R1 clamp cmd", v, 32'h0);
    chk("R2 always-on request", 32'(swReq), 32'h01);
    chk("R2 always-on clamp", 32'(clampEn), 32'hFE);

    // R3 power on partition 3
    wr(2'd0, 32'h103);
    rd(2'd0, v); chk("R3 busy readback", v, 32'h103);
    chk("R3 request raised", 32'(swReq), 32'h09);
    rd(2'd1, v); chk("R10 status held while busy", v, 32'h01);
    waitIdle();
    rd(2'd1, v); chk("R3 powered", v, 32'h09);
    rd(2'd0, v); chk("R3 start cleared", v, 32'h003);

    // R7 clamp removal for partition 3
    wr(2'd2, 32'h08);
    rd(2'd2, v); chk("R7 cmd set", v, 32'h08);
    repeat (3) @(negedge clk);
    rd(2'd2, v); chk("R7 cmd still set", v, 32'h08);
    @(negedge clk);
    rd(2'd2, v); chk("R7 cmd self-cleared", v, 32'h0);
    rd(2'd3, v); chk("R7 clamp status", v, 32'hF6);
    chk("R7 clampEn port", 32'(clampEn), 32'hF6);

    // R8 unpowered partition 5
    wr(2'd2, 32'h20);
    rd(2'd2, v); chk("R8 unpowered cmd", v, 32'h0);
    rd(2'd3, v); chk("R8 unpowered clamp", v, 32'hF6);

    // R5 busy toggle dropped; R8 clamp on partition mid-toggle
    wr(2'd0, 32'h106);
    wr(2'd0, 32'h105);
    wr(2'd2, 32'h40);
    rd(2'd2, v); chk("R8 mid-toggle cmd", v, 32'h0);
    waitIdle();
    rd(2'd1, v); chk("R5 dropped toggle", v, 32'h49);
    rd(2'd0, v); chk("R5 sticky error", v, 32'h10006);
    rd(2'd3, v); chk("R8 mid-toggle clamp", v, 32'hF6);

    // R9 two-hot and pending-removal writes
    wr(2'd2, 32'h48);
    rd(2'd2, v); chk("R9 two-hot cmd", v, 32'h0);
    rd(2'd3, v); chk("R9 two-hot clamp", v, 32'hF6);
    wr(2'd2, 32'h40);
    wr(2'd2, 32'h08);
    rd(2'd2, v); chk("R9 pending write ignored", v, 32'h40);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R9 cmd cleared", v, 32'h0);
    rd(2'd3, v); chk("R9 only partition 6 released", v, 32'hB6);

    // R6 ignored toggle writes
    wr(2'd0, 32'h004);
    rd(2'd0, v); chk("R6 no start bit", v, 32'h10006);
    wr(2'd0, 32'h10A);
    rd(2'd0, v); chk("R6 index out of range", v, 32'h10006);
    rd(2'd1, v); chk("R6 power unchanged", v, 32'h49);

    // R4 power off partition 3
    wr(2'd0, 32'h103);
    chk("R4 clamp raised first", 32'(clampEn[3]), 32'h1);
    chk("R4 request still high", 32'(swReq[3]), 32'h1);
    @(negedge clk);
    chk("R4 request dropped", 32'(swReq[3]), 32'h0);
    waitIdle();
    rd(2'd1, v); chk("R4 powered off", v, 32'h41);
    rd(2'd3, v); chk("R4 clamp status", v, 32'hBE);

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule